// File: doc/BRIEF.md
# Write Enable and Protection Controller

This block sits between the serial command front end of a small flash memory and its array sequencer. It owns the status byte and decides whether each modifying command goes ahead. The front end presents one strobe per finished transaction. The strobe carries the opcode, the 18-bit address, and a flag that says whether the transaction ended on a whole byte. The controller tracks the write-enable latch, the busy flag and the power-down state. When a command is granted, it issues a one-cycle grant carrying the operation kind and the address, and it runs the matching self-timed duration on an internal down-counter.

Two pins also feed the controller. The protect pin shields the lowest pages of the array, and the hardware reset pin has effect only when no operation is running. A granted operation keeps write enable set until its timer expires, and then clears it. A command that is refused for any reason leaves write enable as it was. Durations are parameters, kept short so that a simulation finishes quickly.

Top module: `wpc_ctrl`

## Requirements
- R1: `status` reads busy in bit 0 and write enable in bit 1, with bits 7..2 always 0. It shows the live state, including while busy. After `rst_n` it reads 00h and `pd_active` is 0.
- R2: With the block idle and not powered down, a whole transaction with opcode 06h sets write enable and one with opcode 04h clears it, visible one cycle after the strobe.
- R3: With write enable 1 and no protection hit, a whole transaction with a modifying opcode raises `grant` for exactly one cycle, one cycle after the strobe, and sets busy in that same cycle. `grant_addr` equals the command address and `grant_kind` is one of: DBh page erase = 1, D8h sector erase = 2, C7h chip erase = 3, 02h page program = 4, 0Ah page write = 5.
- R4: Busy stays 1 for exactly the duration parameter of the granted kind, in cycles, counting the grant cycle. When it falls, write enable falls in the same cycle.
- R5: A strobe with `cmd_whole` = 0 is ignored for every opcode, and write enable is unchanged.
- R6: While busy, every command is ignored, including 06h and 04h. A modifying opcode with write enable 0 is not granted.
- R7: With `wp_n` low, the following are refused and leave write enable unchanged: page erase, program or page write at an address below PROT_PAGES pages; sector erase of a sector overlapping that range; and any chip erase. With `wp_n` high, the same commands are granted.
- R8: Opcode B9h sets `pd_active`. While it is set, every opcode except ABh is ignored, and ABh clears it.
- R9: `hrst_n` low while idle clears write enable and `pd_active` on the next cycle, and a command in that cycle is ignored. While busy, `hrst_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_vld | input | 1 | One-cycle strobe of a finished transaction |
| cmd_op | input | 8 | Opcode of the transaction |
| cmd_addr | input | ADDR_W | Byte address of the transaction |
| cmd_whole | input | 1 | Transaction ended on a byte boundary with its full length |
| wp_n | input | 1 | Protect pin, low shields the lowest pages |
| hrst_n | input | 1 | Hardware reset pin, active low, sampled synchronously |
| status | output | 8 | Status byte {6'b0, write enable, busy} |
| grant | output | 1 | One-cycle start pulse for the array sequencer |
| grant_kind | output | 3 | Kind code of the granted operation |
| grant_addr | output | ADDR_W | Address of the granted operation |
| pd_active | output | 1 | Power-down state |

## Verification
Every result of a strobe sampled at clock edge E appears right after E. `status`, `pd_active` and the grant pulse are all direct register outputs. The bench therefore drives inputs on falling edges and reads outputs on the next falling edge. The end of busy is due a fixed number of cycles after the grant edge. The bench counts the cycles it has already spent since the grant, including commands it issued in the meantime. It checks that busy is still 1 one cycle before the due edge and 0 right after it, so a duration that is off by one in either direction is caught.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_PAGE_ER = 3'd1,
        K_SECT_ER = 3'd2,
        K_CHIP_ER = 3'd3,
        K_PROG    = 3'd4,
        K_PWRITE  = 3'd5
    } kind_e;

    localparam logic [7:0] OPC_WEN_SET = 8'h06;
    localparam logic [7:0] OPC_WEN_CLR = 8'h04;
    localparam logic [7:0] OPC_SLEEP   = 8'hB9;
    localparam logic [7:0] OPC_WAKE    = 8'hAB;
    localparam logic [7:0] OPC_PAGE_ER = 8'hDB;
    localparam logic [7:0] OPC_SECT_ER = 8'hD8;
    localparam logic [7:0] OPC_CHIP_ER = 8'hC7;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_PWRITE  = 8'h0A;

endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
    import wpc_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int T_PAGE_ER = 12,
    parameter int T_SECT_ER = 20,
    parameter int T_CHIP_ER = 28,
    parameter int T_PROG    = 8,
    parameter int T_PWRITE  = 16
) (
    input  logic [7:0]       op,
    output kind_e            kind,
    output logic             is_set,
    output logic             is_clr,
    output logic             is_sleep,
    output logic             is_wake,
    output logic [CNT_W-1:0] dur
);
    always_comb begin
        kind     = K_NONE;
        dur      = '0;
        is_set   = (op == OPC_WEN_SET);
        is_clr   = (op == OPC_WEN_CLR);
        is_sleep = (op == OPC_SLEEP);
        is_wake  = (op == OPC_WAKE);
        case (op)
            OPC_PAGE_ER: begin kind = K_PAGE_ER; dur = CNT_W'(T_PAGE_ER); end
            OPC_SECT_ER: begin kind = K_SECT_ER; dur = CNT_W'(T_SECT_ER); end
            OPC_CHIP_ER: begin kind = K_CHIP_ER; dur = CNT_W'(T_CHIP_ER); end
            OPC_PROG:    begin kind = K_PROG;    dur = CNT_W'(T_PROG);    end
            OPC_PWRITE:  begin kind = K_PWRITE;  dur = CNT_W'(T_PWRITE);  end
            default:     begin kind = K_NONE;    dur = '0;                end
        endcase
    end
endmodule

// File: rtl/wpc_guard.sv
module wpc_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_BITS  = 8,
    parameter int SECT_BITS  = 16,
    parameter int PROT_PAGES = 256
) (
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_n,
    output logic              blocked
);
    localparam longint PROT_BYTES = longint'(PROT_PAGES) << PAGE_BITS;
    localparam longint SECT_SIZE  = longint'(1) << SECT_BITS;
    localparam longint SECT_LIM   = ((PROT_BYTES + SECT_SIZE - 1) / SECT_SIZE) * SECT_SIZE;
    localparam logic [ADDR_W:0] PAGE_EDGE = (ADDR_W+1)'(PROT_BYTES);
    localparam logic [ADDR_W:0] SECT_EDGE = (ADDR_W+1)'(SECT_LIM);

    logic [ADDR_W:0] a_ext;
    logic            in_pages;
    logic            in_sects;

    always_comb begin
        a_ext    = {1'b0, addr};
        in_pages = (a_ext < PAGE_EDGE);
        in_sects = (a_ext < SECT_EDGE);
        blocked  = 1'b0;
        if (!wp_n) begin
            case (kind)
                K_PAGE_ER, K_PROG, K_PWRITE: blocked = in_pages;
                K_SECT_ER:                   blocked = in_sects;
                K_CHIP_ER:                   blocked = (PROT_PAGES > 0);
                default:                     blocked = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wpc_timer.sv
module wpc_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_BITS  = 8,
    parameter int SECT_BITS  = 16,
    parameter int PROT_PAGES = 256,
    parameter int T_PAGE_ER  = 12,
    parameter int T_SECT_ER  = 20,
    parameter int T_CHIP_ER  = 28,
    parameter int T_PROG     = 8,
    parameter int T_PWRITE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_whole,
    input  logic              wp_n,
    input  logic              hrst_n,
    output logic [7:0]        status,
    output logic              grant,
    output logic [2:0]        grant_kind,
    output logic [ADDR_W-1:0] grant_addr,
    output logic              pd_active
);
    localparam int T_M1  = (T_PAGE_ER > T_SECT_ER) ? T_PAGE_ER : T_SECT_ER;
    localparam int T_M2  = (T_CHIP_ER > T_PROG) ? T_CHIP_ER : T_PROG;
    localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX = (T_M3 > T_PWRITE) ? T_M3 : T_PWRITE;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic              wen;
        logic              busy;
        logic              pd;
        logic              grant;
        kind_e             gkind;
        logic [ADDR_W-1:0] gaddr;
    } st_t;

    st_t st_d, st_q;

    kind_e            kind;
    logic             is_set, is_clr, is_sleep, is_wake;
    logic [CNT_W-1:0] dur;
    logic             blocked;
    logic             tmr_load;
    logic             tmr_done;

    wpc_decode #(
        .CNT_W(CNT_W), .T_PAGE_ER(T_PAGE_ER), .T_SECT_ER(T_SECT_ER),
        .T_CHIP_ER(T_CHIP_ER), .T_PROG(T_PROG), .T_PWRITE(T_PWRITE)
    ) u_dec (
        .op(cmd_op), .kind(kind), .is_set(is_set), .is_clr(is_clr),
        .is_sleep(is_sleep), .is_wake(is_wake), .dur(dur)
    );

    wpc_guard #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SECT_BITS(SECT_BITS),
        .PROT_PAGES(PROT_PAGES)
    ) u_guard (
        .kind(kind), .addr(cmd_addr), .wp_n(wp_n), .blocked(blocked)
    );

    wpc_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(dur), .done(tmr_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        tmr_load   = 1'b0;
        if (st_q.busy) begin
            // a running operation masks commands and the reset pin
            if (tmr_done) begin
                st_d.busy = 1'b0;
                st_d.wen  = 1'b0;
            end
        end else if (!hrst_n) begin
            st_d.wen = 1'b0;
            st_d.pd  = 1'b0;
        end else if (cmd_vld && cmd_whole) begin
            if (st_q.pd) begin
                if (is_wake) st_d.pd = 1'b0;
            end else if (is_set) begin
                st_d.wen = 1'b1;
            end else if (is_clr) begin
                st_d.wen = 1'b0;
            end else if (is_sleep) begin
                st_d.pd = 1'b1;
            end else if (kind != K_NONE && st_q.wen && !blocked) begin
                st_d.busy  = 1'b1;
                st_d.grant = 1'b1;
                st_d.gkind = kind;
                st_d.gaddr = cmd_addr;
                tmr_load   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wen: 1'b0, busy: 1'b0, pd: 1'b0, grant: 1'b0,
                      gkind: K_NONE, gaddr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status     = {6'b0, st_q.wen, st_q.busy};
    assign grant      = st_q.grant;
    assign grant_kind = st_q.gkind;
    assign grant_addr = st_q.gaddr;
    assign pd_active  = st_q.pd;
endmodule

// File: rtl/wpc_chk.sv
module wpc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_vld,
    input logic [7:0] cmd_op,
    input logic       cmd_whole,
    input logic       wp_n,
    input logic       hrst_n,
    input logic [7:0] status,
    input logic       grant,
    input logic [2:0] grant_kind,
    input logic       pd_active
);
    // R1
    status_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:2] == 6'b0);

    // R3
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (status[0] && status[1]));

    // R4
    done_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    // R6
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> !grant);

    // R7
    chip_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_kind == 3'd3) |-> $past(wp_n));

    // R8
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && hrst_n && !(cmd_vld && cmd_whole && cmd_op == 8'hAB)) |=> pd_active);

    // R8
    pd_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |=> !grant);

    // R9
    idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !hrst_n) |=> (!status[1] && !pd_active));
endmodule

bind wpc_ctrl wpc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .wp_n(wp_n), .hrst_n(hrst_n), .status(status),
    .grant(grant), .grant_kind(grant_kind), .pd_active(pd_active)
);

// File: tb/tb_wpc_ctrl.sv
module tb_wpc_ctrl;
    localparam int AW   = 18;
    localparam int D_PE = 12;
    localparam int D_SE = 20;
    localparam int D_CE = 28;
    localparam int D_PP = 8;
    localparam int D_PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_vld = 1'b0;
    logic [7:0]    cmd_op = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_whole = 1'b1;
    logic          wp_n = 1'b1;
    logic          hrst_n = 1'b1;
    logic [7:0]    status;
    logic          grant;
    logic [2:0]    grant_kind;
    logic [AW-1:0] grant_addr;
    logic          pd_active;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wpc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_whole(cmd_whole), .wp_n(wp_n), .hrst_n(hrst_n),
        .status(status), .grant(grant), .grant_kind(grant_kind),
        .grant_addr(grant_addr), .pd_active(pd_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the falling edge after the sampling edge
    task automatic send(input logic [7:0] op, input logic [AW-1:0] a, input logic whole);
        cmd_vld = 1'b1; cmd_op = op; cmd_addr = a; cmd_whole = whole;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_whole = 1'b1;
    endtask

    task automatic pulse_hrst();
        hrst_n = 1'b0;
        @(negedge clk);
        hrst_n = 1'b1;
    endtask

    task automatic wait_idle(input int dur, input int spent, input string req);
        repeat (dur - 1 - spent) @(negedge clk);
        chk({req, " busy one cycle before end"}, 32'(status), 32'h03);
        @(negedge clk);
        chk({req, " idle and wen cleared at end"}, 32'(status), 32'h00);
    endtask

    task automatic t_reset();
        chk("R1 reset status", 32'(status), 32'h00);
        chk("R1 reset pd", 32'(pd_active), 32'h0);
        chk("R1 reset grant", 32'(grant), 32'h0);
    endtask

    task automatic t_wen();
        send(8'h06, '0, 1'b1);
        chk("R2 set wen", 32'(status), 32'h02);
        send(8'h04, '0, 1'b1);
        chk("R2 clear wen", 32'(status), 32'h00);
    endtask

    task automatic t_no_wen();
        send(8'h02, 18'h20000, 1'b1);
        chk("R6 no grant without wen", 32'(grant), 32'h0);
        chk("R6 status unchanged", 32'(status), 32'h00);
    endtask

    task automatic t_program();
        send(8'h06, '0, 1'b1);
        send(8'h02, 18'h20012, 1'b1);
        chk("R3 program grant", 32'(grant), 32'h1);
        chk("R3 program kind", 32'(grant_kind), 32'd4);
        chk("R3 program addr", 32'(grant_addr), 32'h20012);
        chk("R1 busy visible", 32'(status), 32'h03);
        send(8'h04, '0, 1'b1);
        chk("R3 grant one cycle", 32'(grant), 32'h0);
        chk("R6 wen clear ignored while busy", 32'(status), 32'h03);
        wait_idle(D_PP, 1, "R4 program");
    endtask

    task automatic t_pwrite_busy_cmd();
        send(8'h06, '0, 1'b1);
        send(8'h0A, 18'h3FF00, 1'b1);
        chk("R3 page write kind", 32'(grant_kind), 32'd5);
        send(8'hDB, 18'h30000, 1'b1);
        chk("R6 no grant while busy", 32'(grant), 32'h0);
        send(8'hB9, '0, 1'b1);
        chk("R6 sleep ignored while busy", 32'(pd_active), 32'h0);
        wait_idle(D_PW, 2, "R4 page write");
    endtask

    task automatic t_partial();
        send(8'h06, '0, 1'b1);
        send(8'hDB, 18'h30100, 1'b0);
        chk("R5 partial not granted", 32'(grant), 32'h0);
        chk("R5 wen kept", 32'(status), 32'h02);
        send(8'h04, '0, 1'b0);
        chk("R5 partial wen clear ignored", 32'(status), 32'h02);
        send(8'h04, '0, 1'b1);
    endtask

    task automatic t_protect();
        wp_n = 1'b0;
        send(8'h06, '0, 1'b1);
        send(8'hDB, 18'h0FF00, 1'b1);
        chk("R7 page erase refused", 32'(grant), 32'h0);
        chk("R7 wen kept", 32'(status), 32'h02);
        send(8'h0A, 18'h00005, 1'b1);
        chk("R7 page write refused", 32'(grant), 32'h0);
        send(8'hD8, 18'h00000, 1'b1);
        chk("R7 sector 0 refused", 32'(grant), 32'h0);
        send(8'hC7, '0, 1'b1);
        chk("R7 chip erase refused", 32'(grant), 32'h0);
        chk("R7 wen still kept", 32'(status), 32'h02);
        send(8'hD8, 18'h10000, 1'b1);
        chk("R7 sector 1 allowed", 32'(grant), 32'h1);
        chk("R3 sector kind", 32'(grant_kind), 32'd2);
        wait_idle(D_SE, 0, "R4 sector erase");
        send(8'h06, '0, 1'b1);
        send(8'h02, 18'h10000, 1'b1);
        chk("R7 page above range allowed", 32'(grant), 32'h1);
        wait_idle(D_PP, 0, "R4 program above range");
        wp_n = 1'b1;
        send(8'h06, '0, 1'b1);
        send(8'hC7, '0, 1'b1);
        chk("R7 chip erase unprotected", 32'(grant), 32'h1);
        chk("R3 chip kind", 32'(grant_kind), 32'd3);
        wait_idle(D_CE, 0, "R4 chip erase");
        send(8'h06, '0, 1'b1);
        send(8'hDB, 18'h00100, 1'b1);
        chk("R3 page erase kind", 32'(grant_kind), 32'd1);
        wait_idle(D_PE, 0, "R4 page erase");
    endtask

    task automatic t_powerdown();
        send(8'hB9, '0, 1'b1);
        chk("R8 enter pd", 32'(pd_active), 32'h1);
        send(8'h06, '0, 1'b1);
        chk("R8 wen set ignored in pd", 32'(status), 32'h00);
        send(8'hAB, '0, 1'b0);
        chk("R8 partial wake ignored", 32'(pd_active), 32'h1);
        send(8'hAB, '0, 1'b1);
        chk("R8 wake", 32'(pd_active), 32'h0);
        send(8'h06, '0, 1'b1);
        chk("R8 wen works after wake", 32'(status), 32'h02);
    endtask

    task automatic t_hrst();
        send(8'hB9, '0, 1'b1);
        pulse_hrst();
        chk("R9 idle reset clears wen", 32'(status), 32'h00);
        chk("R9 idle reset leaves pd", 32'(pd_active), 32'h0);
        send(8'h06, '0, 1'b1);
        send(8'hD8, 18'h30000, 1'b1);
        chk("R3 sector grant", 32'(grant), 32'h1);
        pulse_hrst();
        chk("R9 reset masked while busy", 32'(status), 32'h03);
        wait_idle(D_SE, 1, "R9 sector after masked reset");
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wen();
        t_no_wen();
        t_program();
        t_pwrite_busy_cmd();
        t_partial();
        t_protect();
        t_powerdown();
        t_hrst();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule